// File: doc/BRIEF.md
# Longest-Prefix Match Table with Length Comparison Tree

This block is a small associative route table. Each slot holds a 32-bit network address, a prefix length and a valid flag. When a key is presented, every slot works out how many leading bits it shares with the key. It does this in 8-bit groups, most significant group first, and keeps the count as thermometer codes: one code for the whole groups that agree and one for the agreeing leading bits of the first group that disagrees. Bits below a slot's stored prefix length take no part in its comparison. A slot matches when its agreeing length reaches its prefix length, and it then offers that prefix length as its score.

A pipelined tree of pairwise comparators reduces the scores. Each node forwards the larger score together with the slot index it came from. The index that reaches the root is the next-hop pointer. Slots may be written in any order, so the table never needs sorting. A new key is accepted every cycle, and the result appears a fixed number of cycles later.

Top module: `lpm_cam`

## Requirements
- R1: After reset all slots are invalid and the outputs res_vld_o, res_hit_o, res_len_o and res_idx_o are zero. A search of an empty table reports no hit.
- R2: A write with wr_en_i high stores the address, valid flag and prefix length in slot wr_idx_i. A length above 32 is stored as 32. A search issued in the same cycle as a write sees the old contents, and a search one cycle later sees the new contents.
- R3: A valid slot matches a key exactly when the key's leading prefix-length bits equal the slot's leading prefix-length bits. The lower bits of either value have no effect.
- R4: On a hit, res_len_o equals the stored prefix length of the winning slot (0 to 32).
- R5: Among all matching slots, the one with the greatest prefix length wins, wherever it sits in the table.
- R6: When several matching slots share the greatest length, the lowest slot index wins.
- R7: A valid slot with prefix length 0 matches every key and gives res_hit_o=1, res_len_o=0.
- R8: When no slot matches, res_hit_o=0, res_len_o=0 and res_idx_o=0.
- R9: The result of a search with srch_en_i high at a clock edge appears with res_vld_o=1 after 1+log2(N_ENTRIES) edges (5 for 16 slots). Searches may be issued on consecutive cycles, and each one yields exactly one result cycle.
- R10: A slot written with wr_vld_i=0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | log2(N_ENTRIES) | Slot to write |
| wr_addr_i | input | 32 | Network address to store |
| wr_len_i | input | 6 | Prefix length (values above 32 clamp to 32) |
| wr_vld_i | input | 1 | Valid flag to store |
| srch_en_i | input | 1 | Search strobe |
| srch_key_i | input | 32 | Search key |
| res_vld_o | output | 1 | Result valid |
| res_hit_o | output | 1 | Some slot matched |
| res_len_o | output | 6 | Prefix length of the winner |
| res_idx_o | output | log2(N_ENTRIES) | Index of the winner (next-hop pointer) |

## Verification
A wrong valid bit or stored length in a slot changes the winner or the hit flag of the first search that touches that slot, five cycles after the key is issued. A stale comparison in a tree node shows up as a wrong index or length in the result one cycle per level later. Ties and the zero-length route are the cases most likely to hide a fault, because a faulty node can still return the right length with the wrong index. For that reason index, length and hit are each compared separately on every result cycle, and back-to-back searches expose any mix-up between pipeline stages.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned GRP_W  = 8;
  localparam int unsigned N_GRP  = ADDR_W / GRP_W;
  localparam int unsigned LEN_W  = $clog2(ADDR_W + 1);
  localparam int unsigned CNT_W  = $clog2(N_GRP + 1);
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LEN_W-1:0]  len_t;
endpackage

// File: rtl/lpm_entry.sv
`timescale 1ns/1ps
// Per-slot match length: group thermometer plus partial-group thermometer.
module lpm_entry import lpm_pkg::*; (
  input  addr_t ent_addr_i,
  input  len_t  ent_len_i,
  input  logic  ent_vld_i,
  input  addr_t key_i,
  output logic  hit_o,
  output len_t  len_o
);
  addr_t             care, diff;
  logic [N_GRP-1:0]  grp_eq, grp_thermo;
  logic [GRP_W-1:0]  part_diff, part_thermo;
  logic [CNT_W-1:0]  full_cnt;
  len_t              raw_len;

  always_comb begin
    // bits below the prefix are excluded from the compare
    care = ~({ADDR_W{1'b1}} >> ent_len_i);
    diff = (ent_addr_i ^ key_i) & care;
    for (int g = 0; g < int'(N_GRP); g++)
      grp_eq[g] = ~|diff[ADDR_W-1-g*GRP_W -: GRP_W];
    grp_thermo[0] = grp_eq[0];
    for (int g = 1; g < int'(N_GRP); g++)
      grp_thermo[g] = grp_thermo[g-1] & grp_eq[g];
    full_cnt = CNT_W'($countones(grp_thermo));
    part_diff = '0;
    for (int g = 0; g < int'(N_GRP); g++)
      if (int'(full_cnt) == g) part_diff = diff[ADDR_W-1-g*GRP_W -: GRP_W];
    part_thermo[GRP_W-1] = ~part_diff[GRP_W-1];
    for (int b = GRP_W-2; b >= 0; b--)
      part_thermo[b] = part_thermo[b+1] & ~part_diff[b];
    if (int'(full_cnt) == int'(N_GRP)) raw_len = len_t'(ADDR_W);
    else raw_len = len_t'(int'(full_cnt) * int'(GRP_W) + $countones(part_thermo));
    hit_o = ent_vld_i && (raw_len >= ent_len_i);
    len_o = hit_o ? ent_len_i : '0;
  end
endmodule

// File: rtl/lpm_table.sv
`timescale 1ns/1ps
module lpm_table import lpm_pkg::*; #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  addr_t            wr_addr_i,
  input  len_t             wr_len_i,
  input  logic             wr_vld_i,
  input  addr_t            key_i,
  output logic             leaf_hit_o [N_ENTRIES],
  output len_t             leaf_len_o [N_ENTRIES]
);
  addr_t ent_addr_q [N_ENTRIES];
  len_t  ent_len_q  [N_ENTRIES];
  logic  ent_vld_q  [N_ENTRIES];
  len_t  wr_len_clamped;

  assign wr_len_clamped = (wr_len_i > len_t'(ADDR_W)) ? len_t'(ADDR_W) : wr_len_i;

  for (genvar i = 0; i < int'(N_ENTRIES); i++) begin : g_slot
    logic hit_c;
    len_t len_c;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_addr_q[i] <= '0;
        ent_len_q[i]  <= '0;
        ent_vld_q[i]  <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
        ent_addr_q[i] <= wr_addr_i;
        ent_len_q[i]  <= wr_len_clamped;
        ent_vld_q[i]  <= wr_vld_i;
      end
    end

    lpm_entry u_entry (
      .ent_addr_i (ent_addr_q[i]),
      .ent_len_i  (ent_len_q[i]),
      .ent_vld_i  (ent_vld_q[i]),
      .key_i      (key_i),
      .hit_o      (hit_c),
      .len_o      (len_c)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        leaf_hit_o[i] <= 1'b0;
        leaf_len_o[i] <= '0;
      end else begin
        leaf_hit_o[i] <= hit_c;
        leaf_len_o[i] <= len_c;
      end
    end

    // R7
    zero_len_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ent_vld_q[i] && ent_len_q[i] == '0) |=> leaf_hit_o[i]);
    // R10
    invalid_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ent_vld_q[i] |=> !leaf_hit_o[i]);
  end

  // R2
  wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ent_vld_q[$past(wr_idx_i)] == $past(wr_vld_i));
endmodule

// File: rtl/lpm_tree.sv
`timescale 1ns/1ps
// Pipelined max tree over (hit, len); heap layout, leaves at N-1..2N-2.
module lpm_tree import lpm_pkg::*; #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             leaf_hit_i [N_ENTRIES],
  input  len_t             leaf_len_i [N_ENTRIES],
  output logic             root_hit_o,
  output len_t             root_len_o,
  output logic [IDX_W-1:0] root_idx_o
);
  localparam int unsigned N_INT  = N_ENTRIES - 1;
  localparam int unsigned N_NODE = 2 * N_ENTRIES - 1;

  logic             hit_q [N_INT];
  len_t             len_q [N_INT];
  logic [IDX_W-1:0] idx_q [N_INT];
  logic             all_hit [N_NODE];
  len_t             all_len [N_NODE];
  logic [IDX_W-1:0] all_idx [N_NODE];

  always_comb begin
    for (int k = 0; k < int'(N_INT); k++) begin
      all_hit[k] = hit_q[k];
      all_len[k] = len_q[k];
      all_idx[k] = idx_q[k];
    end
    for (int i = 0; i < int'(N_ENTRIES); i++) begin
      all_hit[N_INT+i] = leaf_hit_i[i];
      all_len[N_INT+i] = leaf_len_i[i];
      all_idx[N_INT+i] = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(N_INT); k++) begin
        hit_q[k] <= 1'b0;
        len_q[k] <= '0;
        idx_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < int'(N_INT); k++) begin
        // right wins only when strictly greater: lower index keeps ties
        if ({all_hit[2*k+2], all_len[2*k+2]} > {all_hit[2*k+1], all_len[2*k+1]}) begin
          hit_q[k] <= all_hit[2*k+2];
          len_q[k] <= all_len[2*k+2];
          idx_q[k] <= all_idx[2*k+2];
        end else begin
          hit_q[k] <= all_hit[2*k+1];
          len_q[k] <= all_len[2*k+1];
          idx_q[k] <= all_idx[2*k+1];
        end
      end
    end
  end

  assign root_hit_o = hit_q[0];
  assign root_len_o = len_q[0];
  assign root_idx_o = idx_q[0];

  for (genvar k = 0; k < int'(N_INT); k++) begin : g_chk
    // R5
    node_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ##1 (len_q[k] >= $past(all_len[2*k+1]) && len_q[k] >= $past(all_len[2*k+2])));
    // R6
    node_tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (all_hit[2*k+1] == all_hit[2*k+2] && all_len[2*k+1] == all_len[2*k+2])
      |=> idx_q[k] == $past(all_idx[2*k+1]));
  end
endmodule

// File: rtl/lpm_cam.sv
`timescale 1ns/1ps
module lpm_cam import lpm_pkg::*; #(
  parameter  int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_addr_i,
  input  logic [5:0]       wr_len_i,
  input  logic             wr_vld_i,
  input  logic             srch_en_i,
  input  logic [31:0]      srch_key_i,
  output logic             res_vld_o,
  output logic             res_hit_o,
  output logic [5:0]       res_len_o,
  output logic [IDX_W-1:0] res_idx_o
);
  localparam int unsigned LAT = 1 + IDX_W;

  logic           leaf_hit [N_ENTRIES];
  len_t           leaf_len [N_ENTRIES];
  logic [LAT-1:0] vld_q;
  len_t           root_len;

  lpm_table #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_addr_i  (wr_addr_i),
    .wr_len_i   (len_t'(wr_len_i)),
    .wr_vld_i   (wr_vld_i),
    .key_i      (srch_key_i),
    .leaf_hit_o (leaf_hit),
    .leaf_len_o (leaf_len)
  );

  lpm_tree #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_tree (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .leaf_hit_i (leaf_hit),
    .leaf_len_i (leaf_len),
    .root_hit_o (res_hit_o),
    .root_len_o (root_len),
    .root_idx_o (res_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], srch_en_i};
  end

  assign res_vld_o = vld_q[LAT-1];
  assign res_len_o = 6'(root_len);

  // R8
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_hit_o |-> (res_len_o == '0 && res_idx_o == '0));
  // R4
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_len_o <= 6'(ADDR_W));
endmodule

// File: tb/tb_lpm_cam.sv
`timescale 1ns/1ps
module tb_lpm_cam;
  localparam int N   = 16;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_vld = 1'b0, srch_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_addr = '0, key = '0;
  logic [5:0]  wr_len = '0;
  logic        res_vld, res_hit;
  logic [5:0]  res_len;
  logic [3:0]  res_idx;

  int total = 0;
  int bad   = 0;

  lpm_cam #(.N_ENTRIES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_addr_i(wr_addr), .wr_len_i(wr_len), .wr_vld_i(wr_vld),
    .srch_en_i(srch_en), .srch_key_i(key),
    .res_vld_o(res_vld), .res_hit_o(res_hit), .res_len_o(res_len), .res_idx_o(res_idx)
  );

  always #10 clk = ~clk;

  // reference model
  logic [31:0] m_addr [N];
  int          m_len  [N];
  bit          m_vld  [N];
  bit p_vld [LAT];
  bit p_hit [LAT];
  int p_len [LAT];
  int p_idx [LAT];

  function automatic void model_search(input logic [31:0] k, output bit h, output int l, output int ix);
    h = 0; l = 0; ix = 0;
    for (int i = 0; i < N; i++) begin
      if (m_vld[i]) begin
        int lead = 0;
        for (int b = 31; b >= 0; b--) begin
          if (m_addr[i][b] != k[b]) break;
          lead++;
        end
        if (lead >= m_len[i] && (!h || m_len[i] > l)) begin
          h = 1; l = m_len[i]; ix = i;
        end
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_addr[i] = '0; m_len[i] = 0; end
      for (int s = 0; s < LAT; s++) begin p_vld[s] = 0; p_hit[s] = 0; p_len[s] = 0; p_idx[s] = 0; end
    end else begin
      for (int s = LAT-1; s > 0; s--) begin
        p_vld[s] = p_vld[s-1]; p_hit[s] = p_hit[s-1]; p_len[s] = p_len[s-1]; p_idx[s] = p_idx[s-1];
      end
      p_vld[0] = srch_en;
      if (srch_en) model_search(key, p_hit[0], p_len[0], p_idx[0]);
      else begin p_hit[0] = 0; p_len[0] = 0; p_idx[0] = 0; end
      if (wr_en) begin
        m_addr[wr_idx] = wr_addr;
        m_len[wr_idx]  = (wr_len > 32) ? 32 : int'(wr_len);
        m_vld[wr_idx]  = wr_vld;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 result valid timing", int'(res_vld), int'(p_vld[LAT-1]));
      if (p_vld[LAT-1]) begin
        chk("R3 hit flag", int'(res_hit), int'(p_hit[LAT-1]));
        chk("R4 length", int'(res_len), p_len[LAT-1]);
        chk("R5 R6 winner index", int'(res_idx), p_idx[LAT-1]);
      end
    end
  end

  task automatic wr(input int idx, input logic [31:0] a, input int len, input bit v);
    wr_en = 1; wr_idx = 4'(idx); wr_addr = a; wr_len = 6'(len); wr_vld = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [31:0] k, input bit eh, input int el, input int ei, input string tag);
    srch_en = 1; key = k;
    @(negedge clk);
    srch_en = 0;
    repeat (LAT-1) @(negedge clk);
    chk({tag, " vld"}, int'(res_vld), 1);
    chk({tag, " hit"}, int'(res_hit), int'(eh));
    chk({tag, " len"}, int'(res_len), el);
    chk({tag, " idx"}, int'(res_idx), ei);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset vld", int'(res_vld), 0);
    chk("R1 reset hit", int'(res_hit), 0);
    chk("R1 reset len", int'(res_len), 0);
    chk("R1 reset idx", int'(res_idx), 0);
    rst_n = 1;
    @(negedge clk);
    look(32'hC0A8_0105, 0, 0, 0, "R1 empty table");

    wr(3,  32'hC0A8_0100, 24, 1);
    wr(9,  32'hC0A8_0180, 25, 1);
    wr(1,  32'hC0A8_0000, 16, 1);
    wr(12, 32'h0000_0000, 0,  1);
    wr(5,  32'hC0A8_01FF, 24, 1);   // same /24 as slot 3, low bits differ
    look(32'hC0A8_0105, 1, 24, 3, "R6 tie lower index");
    look(32'hC0A8_01C8, 1, 25, 9, "R5 longest wins unsorted");
    look(32'hC0A8_FF00, 1, 16, 1, "R3 low bits ignored");
    look(32'h0A00_0001, 1, 0, 12, "R7 default route");
    wr(12, 32'h0000_0000, 0, 0);
    look(32'h0A00_0001, 0, 0, 0, "R10 R8 invalidated default");
    wr(15, 32'h0102_0304, 40, 1);
    look(32'h0102_0304, 1, 32, 15, "R2 clamp length 32");
    look(32'h0102_0305, 0, 0, 0, "R3 host route mismatch");

    // R2 same-cycle write and search, then back-to-back search (R9)
    wr_en = 1; wr_idx = 4'd7; wr_addr = 32'h0A00_0000; wr_len = 6'd8; wr_vld = 1;
    srch_en = 1; key = 32'h0A0B_0C0D;
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
    srch_en = 0;
    repeat (LAT-2) @(negedge clk);
    chk("R2 old contents hit", int'(res_hit), 0);
    chk("R9 first result vld", int'(res_vld), 1);
    @(negedge clk);
    chk("R2 new contents hit", int'(res_hit), 1);
    chk("R2 new contents idx", int'(res_idx), 7);
    chk("R9 second result vld", int'(res_vld), 1);
    @(negedge clk);
    chk("R9 single result cycle", int'(res_vld), 0);

    // mixed traffic checked by the per-cycle model
    for (int c = 0; c < 3000; c++) begin
      wr_en   = ($urandom % 6) == 0;
      wr_idx  = 4'($urandom);
      wr_addr = {16'hC0A8, 16'($urandom)};
      wr_len  = 6'($urandom % 34);
      wr_vld  = ($urandom % 5) != 0;
      srch_en = ($urandom % 3) != 0;
      key     = (($urandom % 8) == 0) ? 32'($urandom) : {16'hC0A8, 16'($urandom)};
      @(negedge clk);
    end
    wr_en = 0; srch_en = 0;
    repeat (LAT + 2) @(negedge clk);
    finish_run();
  end
endmodule